// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Mode-Fault Detection

This block is a serial peripheral interface engine that moves one byte per transfer, either as the clock-generating master or as a slave clocked by an external device. Software sets it up through a small register interface of three byte-wide locations: control, status and data. In master mode, writing the data location starts a transfer. The serial clock is derived from the system clock by a programmable divider. In slave mode, the engine follows an external serial clock while the slave-select input is low.

Three event flags are kept in the status location: transfer complete, overrun and mode fault. Each flag is cleared by a two-step access sequence. A single interrupt output, gated by an enable bit, reports any flag that is set. When a master sees its slave-select input pulled low, it treats this as a bus conflict. Hardware then switches the peripheral off, and the transfer in flight is abandoned.

Register map: address 0 is control, address 1 is status, and address 2 is data. Serial data is kept on two directional pins. `sdo_o` carries outgoing bits and `sdi_i` carries incoming bits, in both roles.

Top module: `spi_port`

## Requirements
- R1: After reset, the control and status locations read 0, the interrupt is low, `sck_o` is low, and both output enables are low.
- R2: While control bit 6 (enable) is 0, `sck_oe_o` and `sdo_oe_o` stay low, and a write to the data location starts no transfer: status stays 0.
- R3: With enable and control bit 4 (master) both set, a write to the data location sends that byte MSB first on `sdo_o` and shifts in 8 bits from `sdi_i`. At completion the received byte becomes readable at the data location and status bit 0 is set.
- R4: In master mode, the serial clock half period is (2 << rate) system clocks when control bit 5 is 1, and (4 << rate) when it is 0. Here rate is control bits 1:0. Status bit 0 is set exactly 16 half periods after the clock edge that takes the data write.
- R5: Control bit 3 (polarity) is the idle level of `sck_o`. Control bit 2 (phase) selects sampling on the first clock edge (0) or the second clock edge (1) of each bit. Looping `sdo_o` back to `sdi_i` returns the sent byte in all four modes.
- R6: `irq_o` is high exactly when control bit 7 is 1 and at least one of status bits 0, 1 or 2 is 1.
- R7: If a transfer completes while status bit 0 is still set, status bit 1 (overrun) is set, and the data location keeps the older byte.
- R8: A status read while bit 0 or bit 1 is set, followed by a read or write of the data location, clears bits 0 and 1. A data access with no such status read before it leaves them set.
- R9: If `ss_ni` is low while the block is enabled master, status bit 2 (mode fault) is set, control bit 6 is cleared by hardware, and any transfer in flight is abandoned with no completion.
- R10: Status bit 2 is cleared only by a status read made while it is set, followed by a control write. A control write with no such status read leaves it set.
- R11: In slave mode with `ss_ni` low, the block drives `sdo_o` (with `sdo_oe_o` high) from the byte written beforehand, and it receives a byte clocked by `sck_i`. Control bit 5 and the rate bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; triggers the flag-clearing side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected location |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe_o | output | 1 | Drive enable for `sck_o` |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data out of the block |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o` |
| ss_ni | input | 1 | Slave select, active low |
| irq_o | output | 1 | Combined event interrupt |

## Verification
The hardest state to reach from the ports is a mode fault that lands in the middle of a master transfer. The bench starts a transfer at the slowest rate and pulls `ss_ni` low about twenty cycles later. It then waits well past the normal completion time to confirm that the abandoned transfer never reports completion. Slave mode is reached by having the bench play the external master: it toggles `sck_i` slowly enough to cover the input synchronisers, presents `sdi_i` on the correct edge for the chosen phase, and collects `sdo_o`. Overrun is provoked by starting a second transfer without the clearing sequence.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic             irq_en;
    logic             en;
    logic             div_bypass;
    logic             mstr;
    logic             cpol;
    logic             cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } addr_e;

  localparam int STAT_DONE  = 0;
  localparam int STAT_OVR   = 1;
  localparam int STAT_FAULT = 2;
endpackage

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
  parameter int RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              bypass_i,
  output logic              tick_o
);
  localparam int MAX_HALF = 4 << ((1 << RATE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  always_comb begin
    half = CNT_W'(2) << rate_i;
    if (!bypass_i) half = half << 1;
  end

  assign tick_o = run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mstr_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              abort_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              ss_act_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

  logic [1:0]        sck_s, ss_s;
  logic              sck_d;
  logic              busy_q, phase_q;
  logic [EDGE_W-1:0] edge_cnt_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic              slave_sel, s_edge, m_edge, edge_evt, lead;
  logic              sample, change, hold_first, m_last, s_last;

  // input synchronisers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s <= 2'b00;
      ss_s  <= 2'b11;
      sck_d <= 1'b0;
    end else begin
      sck_s <= {sck_s[0], sck_i};
      ss_s  <= {ss_s[0], ss_ni};
      sck_d <= sck_s[1];
    end
  end

  assign ss_act_o  = ~ss_s[1];
  assign slave_sel = en_i & ~mstr_i & ss_act_o;
  assign s_edge    = slave_sel & (sck_s[1] ^ sck_d);
  assign m_edge    = busy_q & tick_i;
  assign edge_evt  = m_edge | s_edge;
  assign lead      = mstr_i ? ~phase_q : (sck_s[1] != cpol_i);
  assign sample    = edge_evt & (lead ^ cpha_i);
  assign change    = edge_evt & ~(lead ^ cpha_i);
  // phase 1: first bit is already on the line before the first edge
  assign hold_first = cpha_i & (bit_cnt_q == '0);
  assign rx_next   = {rx_q[DATA_W-2:0], sdi_i};
  assign m_last    = m_edge & (edge_cnt_q == LAST_EDGE);
  assign s_last    = ~mstr_i & sample & (bit_cnt_q == LAST_BIT);

  assign done_o = m_last | s_last;
  assign rx_o   = sample ? rx_next : rx_q;
  assign sdo_o  = tx_q[DATA_W-1];
  assign sck_o  = cpol_i ^ phase_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_q    <= 1'b0;
      edge_cnt_q <= '0;
    end else if (abort_i || !en_i) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      phase_q    <= 1'b0;
      edge_cnt_q <= '0;
    end else if (m_edge) begin
      phase_q    <= ~phase_q;
      edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
      if (m_last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
    end else begin
      if (start_i || (!mstr_i && !slave_sel)) bit_cnt_q <= '0;
      else if (sample) bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + BIT_W'(1);
      if (sample) rx_q <= rx_next;
      if (load_i) tx_q <= load_data_i;
      else if (change && !hold_first) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ss_act_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              load_o,
  output logic              fault_o,
  output logic              spif_o,
  output logic              ovr_o,
  output logic              modf_o,
  output logic [DATA_W-1:0] rd_buf_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic              spif_q, ovr_q, modf_q, arm_x_q, arm_f_q;
  logic [DATA_W-1:0] rd_buf_q;
  logic              ctrl_wr, stat_rd, data_acc, data_wr, clr_x, fault;

  assign ctrl_wr  = wr_en_i & (addr_i == ADDR_CTRL);
  assign stat_rd  = rd_en_i & (addr_i == ADDR_STAT);
  assign data_wr  = wr_en_i & (addr_i == ADDR_DATA);
  assign data_acc = (wr_en_i | rd_en_i) & (addr_i == ADDR_DATA);
  assign clr_x    = data_acc & arm_x_q;
  assign fault    = ctrl_q.en & ctrl_q.mstr & ss_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      spif_q   <= 1'b0;
      ovr_q    <= 1'b0;
      modf_q   <= 1'b0;
      arm_x_q  <= 1'b0;
      arm_f_q  <= 1'b0;
      rd_buf_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i);
      if (fault)   ctrl_q.en <= 1'b0;

      if (stat_rd && modf_q) arm_f_q <= 1'b1;
      if (ctrl_wr && arm_f_q) begin
        modf_q  <= 1'b0;
        arm_f_q <= 1'b0;
      end
      if (fault) modf_q <= 1'b1;

      if (stat_rd && (spif_q || ovr_q)) arm_x_q <= 1'b1;
      else if (data_acc)                arm_x_q <= 1'b0;
      if (clr_x) begin
        spif_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done_i) begin
        if (spif_q && !clr_x) ovr_q <= 1'b1;
        else begin
          spif_q   <= 1'b1;
          rd_buf_q <= rx_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: begin
        rdata_o[STAT_DONE]  = spif_q;
        rdata_o[STAT_OVR]   = ovr_q;
        rdata_o[STAT_FAULT] = modf_q;
      end
      ADDR_DATA: rdata_o = rd_buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign start_o  = data_wr & ctrl_q.en & ctrl_q.mstr & ~busy_i & ~ss_act_i;
  assign load_o   = data_wr & ~busy_i;
  assign fault_o  = fault;
  assign ctrl_o   = ctrl_q;
  assign spif_o   = spif_q;
  assign ovr_o    = ovr_q;
  assign modf_o   = modf_q;
  assign rd_buf_o = rd_buf_q;
  assign irq_o    = ctrl_q.irq_en & (spif_q | ovr_q | modf_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ss_ni,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic              busy_q, ss_act, done, start, load, fault, tick;
  logic              spif_q, ovr_q, modf_q;
  logic [DATA_W-1:0] rx_byte, rd_buf_q;

  spi_port_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .ss_act_i (ss_act),
    .busy_i   (busy_q),
    .done_i   (done),
    .rx_i     (rx_byte),
    .ctrl_o   (ctrl_q),
    .start_o  (start),
    .load_o   (load),
    .fault_o  (fault),
    .spif_o   (spif_q),
    .ovr_o    (ovr_q),
    .modf_o   (modf_q),
    .rd_buf_o (rd_buf_q),
    .irq_o    (irq_o)
  );

  spi_port_clkdiv #(.RATE_W(RATE_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .rate_i   (ctrl_q.rate),
    .bypass_i (ctrl_q.div_bypass),
    .tick_o   (tick)
  );

  spi_port_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_q.en),
    .mstr_i      (ctrl_q.mstr),
    .cpol_i      (ctrl_q.cpol),
    .cpha_i      (ctrl_q.cpha),
    .tick_i      (tick),
    .start_i     (start),
    .load_i      (load),
    .load_data_i (wdata_i),
    .abort_i     (fault),
    .sck_i       (sck_i),
    .ss_ni       (ss_ni),
    .sdi_i       (sdi_i),
    .sdo_o       (sdo_o),
    .sck_o       (sck_o),
    .busy_o      (busy_q),
    .ss_act_o    (ss_act),
    .done_o      (done),
    .rx_o        (rx_byte)
  );

  assign sck_oe_o = ctrl_q.en & ctrl_q.mstr;
  assign sdo_oe_o = ctrl_q.en & (ctrl_q.mstr | ~ss_ni);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_i,
  input logic       spif_i,
  input logic       ovr_i,
  input logic       modf_i,
  input logic [7:0] rd_buf_i,
  input logic       busy_i,
  input logic       irq_i,
  input logic       sck_i,
  input logic       sck_oe_i,
  input logic       sdo_oe_i
);
  // R2
  pins_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[6] |-> (!sck_oe_i && !sdo_oe_i));

  // R6
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[7] && (spif_i || ovr_i || modf_i)) |-> irq_i);

  // R6
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[7] |-> !irq_i);

  // R9
  fault_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_i) |-> !ctrl_i[6]);

  // R7
  overrun_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> ($stable(rd_buf_i) && spif_i));

  // R5
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && ctrl_i[4] && !busy_i) |-> (sck_i == ctrl_i[3]));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_i   (ctrl_q),
  .spif_i   (spif_q),
  .ovr_i    (ovr_q),
  .modf_i   (modf_q),
  .rd_buf_i (rd_buf_q),
  .busy_i   (busy_q),
  .irq_i    (irq_o),
  .sck_i    (sck_o),
  .sck_oe_i (sck_oe_o),
  .sdo_oe_i (sdo_oe_o)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {control, byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h70A5, 16'h543C, 16'hD981, 16'h7E5A, 16'hF3FF, 16'h5300
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sck_drv = 1'b0, sdi_drv = 1'b0, loop = 1'b1, ss_n = 1'b1;
  logic       sck_o, sck_oe, sdo, sdo_oe, irq, sdi;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  assign sdi = loop ? sdo : sdi_drv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_port uut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_en_i (wr_en),
    .rd_en_i (rd_en), .wdata_i (wdata), .rdata_o (rdata),
    .sck_i (sck_drv), .sck_o (sck_o), .sck_oe_o (sck_oe),
    .sdi_i (sdi), .sdo_o (sdo), .sdo_oe_o (sdo_oe),
    .ss_ni (ss_n), .irq_o (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      peek(2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic slave_xfer(input logic byp, input logic cpol, input logic cpha,
                            input logic [7:0] mosi, input logic [7:0] miso);
    logic [7:0] got = 8'h00, v;
    loop = 1'b0; sck_drv = cpol;
    wr(2'd0, {1'b0, 1'b1, byp, 1'b0, cpol, cpha, 2'b11});
    wr(2'd2, miso);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 slave drive enable", int'(sdo_oe), 1);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        sdi_drv = mosi[i];
        repeat (8) @(negedge clk);
        got = {got[6:0], sdo}; sck_drv = ~sck_drv;
        repeat (8) @(negedge clk);
        sck_drv = ~sck_drv;
      end else begin
        sdi_drv = mosi[i]; sck_drv = ~sck_drv;
        repeat (8) @(negedge clk);
        got = {got[6:0], sdo}; sck_drv = ~sck_drv;
      end
      repeat (8) @(negedge clk);
    end
    peek(2'd1, v);
    chk("R11 slave done flag", int'(v), 1);
    ss_n = 1'b1;
    rd(2'd1, v);
    rd(2'd2, v);
    chk("R11 slave received", int'(v), int'(mosi));
    chk("R11 slave sent", int'(got), int'(miso));
    loop = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, half;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    peek(2'd0, v); chk("R1 control", int'(v), 0);
    peek(2'd1, v); chk("R1 status", int'(v), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sck", int'(sck_o), 0);
    chk("R1 enables", int'({sck_oe, sdo_oe}), 0);

    // R2
    wr(2'd0, 8'h10);
    chk("R2 enables", int'({sck_oe, sdo_oe}), 0);
    wr(2'd2, 8'h55);
    repeat (100) @(negedge clk);
    peek(2'd1, v); chk("R2 no transfer", int'(v), 0);

    // R3 R4 R5 R6 R8: master loopback table
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] c, tx;
      c = VEC[k][15:8]; tx = VEC[k][7:0];
      half = (c[5] ? 2 : 4) << c[1:0];
      wr(2'd0, c);
      chk("R5 idle level", int'(sck_o), int'(c[3]));
      @(negedge clk); addr = 2'd2; wdata = tx; wr_en = 1'b1;
      @(posedge clk); #1 wr_en = 1'b0; addr = 2'd1;
      n = 0; seen = 1'b0;
      while (!seen && n < 2000) begin
        @(posedge clk); #1; n++;
        if (rdata[0]) seen = 1'b1;
      end
      chk("R4 transfer cycles", n, 16 * half);
      chk("R6 irq on done", int'(irq), int'(c[7]));
      chk("R5 idle after", int'(sck_o), int'(c[3]));
      rd(2'd1, v); chk("R3 status done", int'(v), 1);
      rd(2'd2, v); chk("R3 loopback byte", int'(v), int'(tx));
      peek(2'd1, v); chk("R8 cleared", int'(v), 0);
      chk("R6 irq cleared", int'(irq), 0);
    end

    // R8: data access without status read keeps flag
    wr(2'd0, 8'h70);
    wr(2'd2, 8'h33);
    wait_done();
    rd(2'd2, v);
    peek(2'd1, v); chk("R8 no clear without status read", int'(v), 1);
    rd(2'd1, v); rd(2'd2, v);
    peek(2'd1, v); chk("R8 clear after sequence", int'(v), 0);

    // R7
    wr(2'd2, 8'h11);
    wait_done();
    wr(2'd2, 8'h22);
    repeat (100) @(negedge clk);
    peek(2'd1, v); chk("R7 overrun flag", int'(v), 3);
    rd(2'd1, v);
    rd(2'd2, v); chk("R7 older byte kept", int'(v), 8'h11);
    peek(2'd1, v); chk("R8 overrun cleared", int'(v), 0);

    // R9: fault during a slow transfer
    wr(2'd0, 8'hD3);
    wr(2'd2, 8'hAA);
    repeat (20) @(negedge clk);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    peek(2'd0, v); chk("R9 enable cleared", int'(v), 8'h93);
    peek(2'd1, v); chk("R9 fault flag", int'(v), 4);
    chk("R6 irq on fault", int'(irq), 1);
    chk("R9 clock released", int'(sck_oe), 0);
    repeat (600) @(negedge clk);
    peek(2'd1, v); chk("R9 transfer abandoned", int'(v), 4);
    ss_n = 1'b1;

    // R10
    wr(2'd0, 8'h80);
    peek(2'd1, v); chk("R10 write alone keeps fault", int'(v), 4);
    rd(2'd1, v);
    wr(2'd0, 8'h80);
    peek(2'd1, v); chk("R10 fault cleared", int'(v), 0);
    chk("R6 irq after clear", int'(irq), 0);

    // R11
    slave_xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h96);
    slave_xfer(1'b1, 1'b0, 1'b0, 8'hC3, 8'h96);
    slave_xfer(1'b0, 1'b1, 1'b1, 8'h5E, 8'hA1);
    slave_xfer(1'b1, 1'b0, 1'b1, 8'h0F, 8'hF0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule